// File: doc/BRIEF.md
# Opcode-Snooping Operand Override Unit

This unit sits between a program ROM and a CPU data bus. It watches every byte fetched from the ROM and recognises two instructions: the immediate-mode load (opcode 0xA9) and the absolute jump (opcode 0x4C). When it recognises one, it replaces that instruction's operand bytes on the bus with values from an external data stream fetcher. The CPU never sees the ROM operand.

For a load, the ROM operand byte becomes a stream selector. The unit issues one read strobe to the fetcher and drives the returned stream byte as the operand, so a plain immediate load reads a hardware stream.

For a jump, the unit needs both target bytes before it decides. The ROM byte at the fetch address and the byte that follows it (the peek input) are available together at the first operand fetch. A target of $0000 takes its destination from jump stream 0, and a target of $0001 from jump stream 1. The unit then drives the low byte and the high byte of that destination in turn. Each taken jump pulls the next entry from its list, so a kernel can branch through a table with a single instruction.

Instruction boundaries are tracked by a small state machine that steps on a new-address strobe. ROM storage and stream RAM sit outside the block.

Top module: `snoop_override`

## Requirements
- R1: While reset is held, `bus_byte` is 0x00, and `stream_rd` and `jmp_rd` are low.
- R2: A fetch that is not a substituted operand drives `rom_byte` onto `bus_byte` one clock after the strobe cycle. `bus_byte` then holds its value until one clock after the next strobe.
- R3: After an opcode 0xA9 at address A, with `fast_fetch_en` high, the fetch at address A+1 works as follows:
  - In that same cycle, `stream_rd` pulses exactly once and `stream_sel` equals the ROM operand.
  - `bus_byte` then carries `stream_data`.
  - The operand is consumed and never treated as an opcode, even if its value is 0xA9.
- R4: With `fast_fetch_en` low, the operand of an 0xA9 opcode passes through unchanged and no stream read occurs. The operand is still consumed, so a 0x4C operand does not start a jump.
- R5: After an opcode 0x4C at address A, when the fetch at A+1 carries target $0000 (`rom_byte` 0x00 and `rom_peek` 0x00):
  - `jmp_rd` pulses in that cycle with `jmp_sel` 0.
  - The A+1 fetch drives bits 7:0 of `jmp_addr`.
  - The A+2 fetch drives bits 15:8 of the value captured at A+1.
- R6: A jump whose target is $0001 (`rom_byte` 0x01, `rom_peek` 0x00) behaves as in R5 but with `jmp_sel` 1.
- R7: A jump to any other target (for example $0100 or $0002) passes both operand bytes through and raises no `jmp_rd`.
- R8: Each taken jump raises exactly one `jmp_rd` pulse. The fetcher advances its list by one two-byte entry per pulse, so successive jumps through the same stream receive successive destinations.
- R9: A fetch whose address is not the previous fetch address plus one is decoded as a new opcode, even when an operand was expected. No substitution happens for it.
- R10: The jump override works regardless of `fast_fetch_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_strobe | input | 1 | One-cycle pulse: a new fetch address and its ROM byte are valid |
| fetch_addr | input | ADDR_W | Address of the current fetch |
| rom_byte | input | DATA_W | ROM byte at `fetch_addr` |
| rom_peek | input | DATA_W | ROM byte at `fetch_addr`+1 |
| fast_fetch_en | input | 1 | Enables the immediate-load override |
| stream_rd | output | 1 | Read strobe to the stream fetcher (load operand) |
| stream_sel | output | DATA_W | Stream selector, the ROM operand |
| stream_data | input | DATA_W | Current byte of the selected stream, valid in the `stream_rd` cycle |
| jmp_rd | output | 1 | Read strobe for one jump-list entry |
| jmp_sel | output | JSEL_W | Which jump stream is read |
| jmp_addr | input | 2*DATA_W | Current entry of the selected jump stream |
| bus_byte | output | DATA_W | Byte driven onto the CPU data bus |

## Verification
The checker assumes the following about the environment:
- The fetcher answers combinationally: `stream_data` and `jmp_addr` are valid in the same cycle as the strobe that requests them.
- Each fetch is announced by exactly one strobe cycle.
- `rom_peek` really is the ROM byte at the next address.

The bench's fetcher model meets these assumptions:
- It computes its responses from the selector and its own read counters, and advances those counters only on the clock edge that ends a strobe cycle.
- Its driver presents one fetch per cycle, with a peek byte consistent with the sequence being played.
- It creates address breaks on purpose to probe the boundary tracking.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LD_OPND = 2'd1,
        ST_JMP_LO  = 2'd2,
        ST_JMP_HI  = 2'd3
    } snoop_state_e;

endpackage

// File: rtl/snoop_decode.sv
module snoop_decode #(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] LD_OPC  = 8'hA9,
    parameter logic [DATA_W-1:0] JMP_OPC = 8'h4C,
    parameter int                NUM_JMP = 2,
    parameter int                JSEL_W  = 1
) (
    input  logic [DATA_W-1:0] cur_byte,
    input  logic [DATA_W-1:0] peek_byte,
    output logic              is_ld,
    output logic              is_jmp,
    output logic              tgt_hit,
    output logic [JSEL_W-1:0] tgt_sel
);

    logic [NUM_JMP-1:0] hit;

    assign is_ld  = (cur_byte == LD_OPC);
    assign is_jmp = (cur_byte == JMP_OPC);

    // one comparator per reserved jump target: high byte zero, low byte = index
    for (genvar i = 0; i < NUM_JMP; i++) begin : g_tgt
        assign hit[i] = (peek_byte == '0) && (cur_byte == DATA_W'(i));
    end

    assign tgt_hit = |hit;

    always_comb begin
        tgt_sel = '0;
        for (int i = 0; i < NUM_JMP; i++) begin
            if (hit[i]) tgt_sel = JSEL_W'(i);
        end
    end

endmodule

// File: rtl/snoop_seq.sv
module snoop_seq
    import snoop_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int JSEL_W = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   cur_byte,
    input  logic                is_ld,
    input  logic                is_jmp,
    input  logic                tgt_hit,
    input  logic [JSEL_W-1:0]   tgt_sel,
    input  logic                fast_en,
    input  logic [DATA_W-1:0]   stream_data,
    input  logic [2*DATA_W-1:0] jmp_addr,
    output logic                stream_rd,
    output logic [DATA_W-1:0]   stream_sel,
    output logic                jmp_rd,
    output logic [JSEL_W-1:0]   jmp_sel,
    output logic [DATA_W-1:0]   bus_byte
);

    typedef struct packed {
        snoop_state_e      st;
        logic [ADDR_W-1:0] nxt;   // address expected for the next operand
        logic              ovr;   // jump operand being substituted
        logic [DATA_W-1:0] hi;    // captured high destination byte
        logic [DATA_W-1:0] out;   // byte on the bus
    } seq_regs_t;

    seq_regs_t q_q, q_d;
    logic      contig;
    logic      opcode_path;

    always_comb begin
        q_d         = q_q;
        stream_rd   = 1'b0;
        jmp_rd      = 1'b0;
        stream_sel  = cur_byte;
        jmp_sel     = tgt_sel;
        contig      = (addr == q_q.nxt);
        opcode_path = (q_q.st == ST_IDLE) || !contig;
        if (strobe) begin
            q_d.out = cur_byte;
            q_d.nxt = addr + 1'b1;
            q_d.ovr = 1'b0;
            if (opcode_path) begin
                if (is_ld)       q_d.st = ST_LD_OPND;
                else if (is_jmp) q_d.st = ST_JMP_LO;
                else             q_d.st = ST_IDLE;
            end else begin
                unique case (q_q.st)
                    ST_LD_OPND: begin
                        q_d.st = ST_IDLE;
                        if (fast_en) begin
                            stream_rd = 1'b1;
                            q_d.out   = stream_data;
                        end
                    end
                    ST_JMP_LO: begin
                        q_d.st = ST_JMP_HI;
                        if (tgt_hit) begin
                            jmp_rd  = 1'b1;
                            q_d.out = jmp_addr[DATA_W-1:0];
                            q_d.hi  = jmp_addr[2*DATA_W-1:DATA_W];
                            q_d.ovr = 1'b1;
                        end
                    end
                    ST_JMP_HI: begin
                        q_d.st = ST_IDLE;
                        if (q_q.ovr) q_d.out = q_q.hi;
                    end
                    default: q_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign bus_byte = q_q.out;

endmodule

// File: rtl/snoop_override.sv
module snoop_override #(
    parameter int                ADDR_W  = 13,
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] LD_OPC  = 8'hA9,
    parameter logic [DATA_W-1:0] JMP_OPC = 8'h4C,
    parameter int                NUM_JMP = 2,
    localparam int               JSEL_W  = (NUM_JMP > 1) ? $clog2(NUM_JMP) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_strobe,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic [DATA_W-1:0]   rom_byte,
    input  logic [DATA_W-1:0]   rom_peek,
    input  logic                fast_fetch_en,
    output logic                stream_rd,
    output logic [DATA_W-1:0]   stream_sel,
    input  logic [DATA_W-1:0]   stream_data,
    output logic                jmp_rd,
    output logic [JSEL_W-1:0]   jmp_sel,
    input  logic [2*DATA_W-1:0] jmp_addr,
    output logic [DATA_W-1:0]   bus_byte
);

    logic              is_ld;
    logic              is_jmp;
    logic              tgt_hit;
    logic [JSEL_W-1:0] tgt_sel;

    snoop_decode #(
        .DATA_W  (DATA_W),
        .LD_OPC  (LD_OPC),
        .JMP_OPC (JMP_OPC),
        .NUM_JMP (NUM_JMP),
        .JSEL_W  (JSEL_W)
    ) u_decode (
        .cur_byte  (rom_byte),
        .peek_byte (rom_peek),
        .is_ld     (is_ld),
        .is_jmp    (is_jmp),
        .tgt_hit   (tgt_hit),
        .tgt_sel   (tgt_sel)
    );

    snoop_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .JSEL_W (JSEL_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (fetch_strobe),
        .addr        (fetch_addr),
        .cur_byte    (rom_byte),
        .is_ld       (is_ld),
        .is_jmp      (is_jmp),
        .tgt_hit     (tgt_hit),
        .tgt_sel     (tgt_sel),
        .fast_en     (fast_fetch_en),
        .stream_data (stream_data),
        .jmp_addr    (jmp_addr),
        .stream_rd   (stream_rd),
        .stream_sel  (stream_sel),
        .jmp_rd      (jmp_rd),
        .jmp_sel     (jmp_sel),
        .bus_byte    (bus_byte)
    );

endmodule

// File: rtl/snoop_override_chk.sv
module snoop_override_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fetch_strobe,
    input logic                fast_fetch_en,
    input logic                stream_rd,
    input logic [DATA_W-1:0]   stream_data,
    input logic                jmp_rd,
    input logic [2*DATA_W-1:0] jmp_addr,
    input logic [DATA_W-1:0]   bus_byte
);

    AST_BUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_strobe |=> $stable(bus_byte)); // R2

    AST_LD_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        stream_rd |-> (fetch_strobe && fast_fetch_en)); // R4

    AST_LD_DRIVES_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        stream_rd |=> (bus_byte == $past(stream_data))); // R3

    AST_LD_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        stream_rd |=> !stream_rd); // R3

    AST_JMP_DRIVES_LO: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_rd |=> (bus_byte == $past(jmp_addr[DATA_W-1:0]))); // R5

    AST_JMP_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_rd |-> fetch_strobe); // R8

    AST_JMP_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_rd |=> !jmp_rd); // R8

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stream_rd, jmp_rd})); // R8

endmodule

bind snoop_override snoop_override_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_strobe  (fetch_strobe),
    .fast_fetch_en (fast_fetch_en),
    .stream_rd     (stream_rd),
    .stream_data   (stream_data),
    .jmp_rd        (jmp_rd),
    .jmp_addr      (jmp_addr),
    .bus_byte      (bus_byte)
);

// File: tb/sim_snoop_override.sv
module sim_snoop_override;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_strobe = 1'b0;
    logic        fast_fetch_en = 1'b0;
    logic        fe_next = 1'b0;
    logic [12:0] fetch_addr = '0;
    logic [7:0]  rom_byte = '0;
    logic [7:0]  rom_peek = '0;
    logic        stream_rd;
    logic [7:0]  stream_sel;
    logic [7:0]  stream_data;
    logic        jmp_rd;
    logic [0:0]  jmp_sel;
    logic [15:0] jmp_addr;
    logic [7:0]  bus_byte;

    int          total = 0;
    int          bad = 0;
    logic [7:0]  ld_cnt = '0;
    logic [14:0] jc0 = '0;
    logic [14:0] jc1 = '0;
    logic [7:0]  last_hi = '0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] sdat(input logic [7:0] s, input logic [7:0] c);
        return (s ^ 8'h3C) + c;
    endfunction

    function automatic logic [15:0] jdat(input logic sel, input logic [14:0] c);
        return (sel ? 16'hB17E : 16'hA004) + {c, 1'b0};
    endfunction

    // stream fetcher model: combinational answer, advance on the strobe edge
    assign stream_data = sdat(stream_sel, ld_cnt);
    assign jmp_addr    = jdat(jmp_sel[0], jmp_sel[0] ? jc1 : jc0);

    always @(posedge clk) begin
        if (stream_rd) ld_cnt <= ld_cnt + 8'd1;
        if (jmp_rd) begin
            if (jmp_sel[0]) jc1 <= jc1 + 15'd1;
            else            jc0 <= jc0 + 15'd1;
        end
    end

    snoop_override u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_strobe  (fetch_strobe),
        .fetch_addr    (fetch_addr),
        .rom_byte      (rom_byte),
        .rom_peek      (rom_peek),
        .fast_fetch_en (fast_fetch_en),
        .stream_rd     (stream_rd),
        .stream_sel    (stream_sel),
        .stream_data   (stream_data),
        .jmp_rd        (jmp_rd),
        .jmp_sel       (jmp_sel),
        .jmp_addr      (jmp_addr),
        .bus_byte      (bus_byte)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // kind: 0 pass-through, 1 load operand, 2 jump stream 0 low, 3 jump stream 1 low, 4 jump high
    task automatic fetch(input logic [12:0] a, input logic [7:0] b, input logic [7:0] pk,
                         input logic [7:0] exp_pass, input int kind, input string tag);
        logic [7:0]  e;
        logic [15:0] j;
        @(negedge clk);
        fast_fetch_en = fe_next;
        fetch_strobe  = 1'b1;
        fetch_addr    = a;
        rom_byte      = b;
        rom_peek      = pk;
        e = exp_pass;
        if (kind == 1) e = sdat(b, ld_cnt);
        if (kind == 2 || kind == 3) begin
            j       = jdat(kind == 3, (kind == 3) ? jc1 : jc0);
            e       = j[7:0];
            last_hi = j[15:8];
        end
        if (kind == 4) e = last_hi;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #1;
        check(stream_rd == (kind == 1), {tag, " stream_rd"}, 16'(stream_rd), 16'(kind == 1));
        if (kind == 1) check(stream_sel == b, {tag, " stream_sel"}, 16'(stream_sel), 16'(b));
        check(jmp_rd == (kind == 2 || kind == 3), {tag, " jmp_rd"}, 16'(jmp_rd), 16'(kind == 2 || kind == 3));
        if (kind == 2 || kind == 3)
            check(jmp_sel[0] == (kind == 3), {tag, " jmp_sel"}, 16'(jmp_sel), 16'(kind == 3));
    endtask

    // monitor: one expected bus byte per strobe, compared a half cycle after the edge
    initial begin
        forever begin
            @(posedge clk);
            if (fetch_strobe) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 scoreboard underflow", 16'(bus_byte), 16'h0);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(bus_byte == e, t, 16'(bus_byte), 16'(e));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bus_byte == 8'h00, "R1 reset bus", 16'(bus_byte), 16'h0);
        check(!stream_rd && !jmp_rd, "R1 reset strobes", 16'({stream_rd, jmp_rd}), 16'h0);
        rst_n = 1'b1;

        fe_next = 1'b0;
        fetch(13'h100, 8'h85, 8'h20, 8'h85, 0, "R2 plain opcode");
        fetch(13'h101, 8'h20, 8'h00, 8'h20, 0, "R2 plain byte");

        fe_next = 1'b1;
        fetch(13'h102, 8'hA9, 8'h05, 8'hA9, 0, "R2 load opcode passes");
        fetch(13'h103, 8'h05, 8'hA9, 8'h00, 1, "R3 load operand from stream");
        fetch(13'h104, 8'hA9, 8'h11, 8'hA9, 0, "R3 second load opcode");
        fetch(13'h105, 8'h11, 8'hA9, 8'h00, 1, "R3 second load operand");

        fe_next = 1'b0;
        fetch(13'h106, 8'hA9, 8'h4C, 8'hA9, 0, "R4 load opcode mode off");
        fetch(13'h107, 8'h4C, 8'h00, 8'h4C, 0, "R4 operand passes");
        fetch(13'h108, 8'h00, 8'h00, 8'h00, 0, "R4 operand not an opcode");
        fetch(13'h109, 8'h00, 8'h00, 8'h00, 0, "R4 plain after");

        fetch(13'h10A, 8'h4C, 8'h00, 8'h4C, 0, "R5 jump opcode");
        fetch(13'h10B, 8'h00, 8'h00, 8'h00, 2, "R5 R10 jump low from stream 0");
        fetch(13'h10C, 8'h00, 8'h4C, 8'h00, 4, "R5 jump high");
        fetch(13'h10D, 8'h4C, 8'h00, 8'h4C, 0, "R8 jump opcode");
        fetch(13'h10E, 8'h00, 8'h00, 8'h00, 2, "R8 next list entry low");
        fetch(13'h10F, 8'h00, 8'h4C, 8'h00, 4, "R8 next list entry high");
        fetch(13'h110, 8'h4C, 8'h01, 8'h4C, 0, "R6 jump opcode");
        fetch(13'h111, 8'h01, 8'h00, 8'h00, 3, "R6 jump low from stream 1");
        fetch(13'h112, 8'h00, 8'h4C, 8'h00, 4, "R6 jump high");

        fetch(13'h113, 8'h4C, 8'h00, 8'h4C, 0, "R7 jump opcode");
        fetch(13'h114, 8'h00, 8'h01, 8'h00, 0, "R7 target 0100 low");
        fetch(13'h115, 8'h01, 8'h4C, 8'h01, 0, "R7 target 0100 high");
        fetch(13'h116, 8'h4C, 8'h02, 8'h4C, 0, "R7 jump opcode");
        fetch(13'h117, 8'h02, 8'h00, 8'h02, 0, "R7 target 0002 low");
        fetch(13'h118, 8'h00, 8'h00, 8'h00, 0, "R7 target 0002 high");

        fe_next = 1'b1;
        fetch(13'h200, 8'hA9, 8'h33, 8'hA9, 0, "R9 load opcode");
        fetch(13'h300, 8'h4C, 8'h01, 8'h4C, 0, "R9 address break makes opcode");
        fetch(13'h301, 8'h01, 8'h00, 8'h00, 3, "R9 jump after break low");
        fetch(13'h302, 8'h00, 8'h00, 8'h00, 4, "R9 jump after break high");
        fetch(13'h400, 8'h4C, 8'h00, 8'h4C, 0, "R9 jump opcode");
        fetch(13'h401, 8'h00, 8'h00, 8'h00, 2, "R9 jump low");
        fetch(13'h500, 8'h77, 8'h00, 8'h77, 0, "R9 high byte abandoned on break");

        fetch(13'h600, 8'hA9, 8'hA9, 8'hA9, 0, "R3 load opcode");
        fetch(13'h601, 8'hA9, 8'h07, 8'h00, 1, "R3 operand equal to opcode");
        fetch(13'h602, 8'h07, 8'h00, 8'h07, 0, "R3 operand consumed");

        @(negedge clk);
        fetch_strobe = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(bus_byte == 8'h07, "R2 hold without strobe", 16'(bus_byte), 16'h07);
        end
        check(ld_cnt == 8'd3, "R3 stream read count", 16'(ld_cnt), 16'd3);
        check(jc0 == 15'd3, "R8 stream 0 jump count", 16'(jc0), 16'd3);
        check(jc1 == 15'd2, "R8 stream 1 jump count", 16'(jc1), 16'd2);
        check(exp_q.size() == 0, "R2 scoreboard drained", 16'(exp_q.size()), 16'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule